// File: doc/BRIEF.md
# Two-Window SRAM Bank Mapper

This block sits between an 8-bit processor with a 16-bit address bus and a memory system made of a large SRAM and a boot EEPROM. It splits the 64KB processor space into two 32KB windows. The lower window (addresses with bit 15 clear) always lands in SRAM, on whichever 32KB page the lower page register names. The upper window (bit 15 set) lands either in the boot EEPROM or in the SRAM page named by the upper page register, depending on a select bit held beside that page number. The SRAM holds sixteen 32KB pages, and the extended SRAM address is the 4-bit page number placed above the 15 window offset bits.

Both registers sit in a 16-byte I/O block at 0x7FF0..0x7FFF. This block always decodes to the registers and is never remapped. Offset 0 holds the lower page. Offset 1 holds the upper page in bits 3:0 and the upper-window select in bit 4. Each window has its own register, so software running in one window can repage the other without disturbing itself. A register write takes effect on the next bus cycle. Setting the select bit with both windows on SRAM gives a 64KB all-SRAM configuration. The upper-window mode is held by a two-state machine: `MODE_BOOT` (upper window on the EEPROM) and `MODE_ALLRAM` (upper window on SRAM). A register write to offset 1 with bit 4 set takes the `MODE_BOOT -> MODE_ALLRAM` transition. A register write to offset 1 with bit 4 clear takes the `MODE_ALLRAM -> MODE_BOOT` transition. Every other cycle holds the state.

Each bus cycle is one clock with `bus_valid` high. Selects, the SRAM address, the write strobes and register read data follow combinationally from the address and the current mapping.

Top module: `bank_mapper`

## Requirements
- R1: After reset the lower page is 0 and the upper window is on the EEPROM. Reading offset 0 returns 0x00 and reading offset 1 returns 0x00.
- R2: A valid cycle below 0x8000 and outside the I/O block asserts only `sram_sel`, with `sram_addr` = {lower page, cpu_addr[14:0]}.
- R3: In `MODE_BOOT`, a valid cycle at 0x8000 or above asserts only `rom_sel`.
- R4: In `MODE_ALLRAM`, a valid cycle at 0x8000 or above asserts only `sram_sel`, with `sram_addr` = {upper page, cpu_addr[14:0]}.
- R5: A read of offset 0 returns {4'b0, lower page}. A read of offset 1 returns {3'b0, select bit, upper page}, where select bit = 1 means SRAM. A read outside the I/O block returns 0x00 on `cpu_rdata`.
- R6: A register write changes the mapping from the next bus cycle on. A write to one register leaves the other register's page and mode unchanged.
- R7: A valid cycle in 0x7FF0..0x7FFF asserts only `reg_sel`, in either mode. Offsets 2..15 read 0x00 and writes to them change no mapping.
- R8: In `MODE_BOOT`, a write to the upper window asserts `rom_we`, so the EEPROM has no write protection. `sram_we` and `rom_we` are asserted only with `cpu_we` and the matching select.
- R9: With `bus_valid` low, no select and no write strobe is asserted and no register changes.
- R10: In `MODE_ALLRAM`, `rom_sel` is never asserted, so all 64KB outside the I/O block is SRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| cpu_we | input | 1 | Bus cycle is a write |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Register read data, 0 when no register is read |
| reg_sel | output | 1 | Cycle hits the page register block |
| sram_sel | output | 1 | SRAM chip select |
| rom_sel | output | 1 | EEPROM chip select |
| sram_we | output | 1 | SRAM write strobe |
| rom_we | output | 1 | EEPROM write strobe |
| sram_addr | output | 19 | Extended SRAM address {page, offset} |

## Verification
A wrong page register or mode state shows up on the first valid cycle into the affected window. The symptom is a wrong upper `sram_addr` field, or a select on the wrong device. A read of offsets 0 and 1 exposes it at once. A write that is applied late shows as the old mapping on the cycle right after the write. A write that corrupts the other register shows as a wrong page on the next access to the other window.

// File: rtl/bank_pkg.sv
package bank_pkg;
    typedef enum logic {
        MODE_BOOT   = 1'b0,
        MODE_ALLRAM = 1'b1
    } mode_e;
endpackage

// File: rtl/bank_regs.sv
module bank_regs
    import bank_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [PAGE_W-1:0] lo_page,
    output logic [PAGE_W-1:0] hi_page,
    output mode_e             mode
);
    mode_e mode_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_BOOT;
        else        mode <= mode_nx;
    end

    // next-state logic
    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MODE_BOOT:   if (wr_hi && wdata[PAGE_W])  mode_nx = MODE_ALLRAM;
            MODE_ALLRAM: if (wr_hi && !wdata[PAGE_W]) mode_nx = MODE_BOOT;
            default:     mode_nx = MODE_BOOT;
        endcase
    end

    // page numbers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_page <= '0;
            hi_page <= '0;
        end else begin
            if (wr_lo) lo_page <= wdata[PAGE_W-1:0];
            if (wr_hi) hi_page <= wdata[PAGE_W-1:0];
        end
    end
endmodule

// File: rtl/bank_decode.sv
module bank_decode
    import bank_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          PAGE_W  = 4,
    parameter int          DATA_W  = 8,
    parameter int          IO_W    = 4,
    parameter logic [15:0] IO_BASE = 16'h7FF0
) (
    input  logic                       bus_valid,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [PAGE_W-1:0]          lo_page,
    input  logic [PAGE_W-1:0]          hi_page,
    input  mode_e                      mode,
    output logic                       reg_sel,
    output logic                       sram_sel,
    output logic                       rom_sel,
    output logic                       sram_we,
    output logic                       rom_we,
    output logic                       wr_lo,
    output logic                       wr_hi,
    output logic [DATA_W-1:0]          rdata,
    output logic [PAGE_W+ADDR_W-2:0]   sram_addr
);
    localparam int WIN_W = ADDR_W - 1;
    localparam logic [IO_W-1:0] OFS_LO = IO_W'(0);
    localparam logic [IO_W-1:0] OFS_HI = IO_W'(1);

    logic            io_hit;
    logic            upper;
    logic [IO_W-1:0] ofs;

    assign io_hit = (cpu_addr[ADDR_W-1:IO_W] == IO_BASE[ADDR_W-1:IO_W]);
    assign upper  = cpu_addr[ADDR_W-1];
    assign ofs    = cpu_addr[IO_W-1:0];

    always_comb begin
        reg_sel  = 1'b0;
        sram_sel = 1'b0;
        rom_sel  = 1'b0;
        if (bus_valid) begin
            if (io_hit)                    reg_sel  = 1'b1;
            else if (!upper)               sram_sel = 1'b1;
            else if (mode == MODE_ALLRAM)  sram_sel = 1'b1;
            else                           rom_sel  = 1'b1;
        end
    end

    assign sram_addr = {(upper ? hi_page : lo_page), cpu_addr[WIN_W-1:0]};
    assign sram_we   = sram_sel & cpu_we;
    assign rom_we    = rom_sel & cpu_we;
    assign wr_lo     = reg_sel & cpu_we & (ofs == OFS_LO);
    assign wr_hi     = reg_sel & cpu_we & (ofs == OFS_HI);

    always_comb begin
        rdata = '0;
        if (reg_sel) begin
            if (ofs == OFS_LO)      rdata[PAGE_W-1:0] = lo_page;
            else if (ofs == OFS_HI) rdata[PAGE_W:0]   = {mode == MODE_ALLRAM, hi_page};
        end
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          PAGE_W  = 4,
    parameter int          DATA_W  = 8,
    parameter int          IO_W    = 4,
    parameter logic [15:0] IO_BASE = 16'h7FF0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     reg_sel,
    output logic                     sram_sel,
    output logic                     rom_sel,
    output logic                     sram_we,
    output logic                     rom_we,
    output logic [PAGE_W+ADDR_W-2:0] sram_addr
);
    logic [PAGE_W-1:0] lo_page, hi_page;
    mode_e             mode;
    logic              wr_lo, wr_hi;

    bank_regs #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(cpu_wdata), .lo_page(lo_page), .hi_page(hi_page), .mode(mode)
    );

    bank_decode #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
        .IO_W(IO_W), .IO_BASE(IO_BASE)
    ) u_dec (
        .bus_valid(bus_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .lo_page(lo_page), .hi_page(hi_page), .mode(mode),
        .reg_sel(reg_sel), .sram_sel(sram_sel), .rom_sel(rom_sel),
        .sram_we(sram_we), .rom_we(rom_we), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .rdata(cpu_rdata), .sram_addr(sram_addr)
    );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_valid,
    input logic                     cpu_we,
    input logic [ADDR_W-1:0]        cpu_addr,
    input logic                     reg_sel,
    input logic                     sram_sel,
    input logic                     rom_sel,
    input logic                     sram_we,
    input logic                     rom_we,
    input logic [PAGE_W+ADDR_W-2:0] sram_addr
);
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_sel, sram_sel, rom_sel}));                              // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> !(reg_sel || sram_sel || rom_sel || sram_we || rom_we)); // R9
    AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we || rom_we) |-> cpu_we);                                       // R8
    AST_ROM_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> cpu_addr[ADDR_W-1]);                                       // R3
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        sram_sel |-> sram_addr[ADDR_W-2:0] == cpu_addr[ADDR_W-2:0]);           // R2
endmodule

bind bank_mapper bank_mapper_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .reg_sel(reg_sel), .sram_sel(sram_sel),
    .rom_sel(rom_sel), .sram_we(sram_we), .rom_we(rom_we), .sram_addr(sram_addr)
);

// File: tb/sim_bank_mapper.sv
`timescale 1ns/1ps
module sim_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        reg_sel, sram_sel, rom_sel, sram_we, rom_we;
    logic [18:0] sram_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [3:0] m_lo = 4'd0, m_hi = 4'd0;
    logic       m_ram = 1'b0;

    always #2.5 clk = ~clk;

    bank_mapper u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .reg_sel(reg_sel), .sram_sel(sram_sel), .rom_sel(rom_sel),
        .sram_we(sram_we), .rom_we(rom_we), .sram_addr(sram_addr)
    );

    function automatic bit is_io(input logic [15:0] a);
        return a[15:4] == 12'h7FF;
    endfunction

    // expected {reg_sel,sram_sel,rom_sel,sram_we,rom_we,rdata,sram_addr}
    function automatic logic [31:0] expect_out(input logic v, input logic we,
                                               input logic [15:0] a);
        logic rs, ss, os;
        logic [7:0] rd;
        logic [18:0] sa;
        rs = 0; ss = 0; os = 0; rd = 8'h00; sa = '0;
        if (v) begin
            if (is_io(a)) begin
                rs = 1;
                if (a[3:0] == 4'd0) rd = {4'b0, m_lo};
                else if (a[3:0] == 4'd1) rd = {3'b0, m_ram, m_hi};
            end else if (!a[15]) begin
                ss = 1; sa = {m_lo, a[14:0]};
            end else if (m_ram) begin
                ss = 1; sa = {m_hi, a[14:0]};
            end else os = 1;
        end
        return {rs, ss, os, ss & we, os & we, rd, sa};
    endfunction

    function automatic string tag_of(input logic v, input logic [15:0] a);
        if (!v) return "R9";
        if (is_io(a)) return (a[3:1] == 3'd0) ? "R5" : "R7";
        if (!a[15]) return "R2";
        return m_ram ? "R4/R10" : "R3/R8";
    endfunction

    task automatic check(input string tag);
        logic [31:0] act, exp;
        act = {reg_sel, sram_sel, rom_sel, sram_we, rom_we, cpu_rdata,
               sram_sel ? sram_addr : 19'd0};
        exp = expect_out(bus_valid, cpu_we, cpu_addr);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h we=%b act=%h exp=%h", tag, cpu_addr, cpu_we, act, exp);
        end
    endtask

    // one bus cycle: drive after negedge, sample mid-cycle, commit at posedge
    task automatic cyc(input logic v, input logic we, input logic [15:0] a,
                       input logic [7:0] d, input string tag);
        @(negedge clk);
        bus_valid = v; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        check(tag.len() ? tag : tag_of(v, a));
        @(posedge clk);
        if (v && we && is_io(a)) begin
            if (a[3:0] == 4'd0) m_lo = d[3:0];
            if (a[3:0] == 4'd1) begin m_hi = d[3:0]; m_ram = d[4]; end
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        cyc(1, 0, 16'h7FF0, 8'h00, "R1");
        cyc(1, 0, 16'h7FF1, 8'h00, "R1");
        cyc(1, 0, 16'hFFFE, 8'h00, "R1");
        cyc(1, 0, 16'h1234, 8'h00, "R2");
        // R8 EEPROM write passes in boot mode
        cyc(1, 1, 16'h9000, 8'hA5, "R8");
        // R6 lower page write, then immediate use
        cyc(1, 1, 16'h7FF0, 8'h0B, "R6");
        cyc(1, 0, 16'h0007, 8'h00, "R6");
        cyc(1, 0, 16'hC000, 8'h00, "R6");
        // R4/R6 switch upper to SRAM page 5
        cyc(1, 1, 16'h7FF1, 8'h15, "R6");
        cyc(1, 1, 16'hFFFF, 8'h3C, "R4");
        cyc(1, 0, 16'h7FF0, 8'h00, "R6");
        cyc(1, 0, 16'h7FF1, 8'h00, "R5");
        cyc(1, 0, 16'h8000, 8'h00, "R10");
        // R7 unused offsets ignored and IO never remapped
        cyc(1, 1, 16'h7FF2, 8'hFF, "R7");
        cyc(1, 1, 16'h7FFF, 8'hFF, "R7");
        cyc(1, 0, 16'h7FF2, 8'h00, "R7");
        cyc(1, 0, 16'h7FF0, 8'h00, "R7");
        cyc(1, 0, 16'h7FF1, 8'h00, "R7");
        // R9 idle ignores write to register
        cyc(0, 1, 16'h7FF0, 8'h02, "R9");
        cyc(1, 0, 16'h7FF0, 8'h00, "R9");
        // R5 non-register read gives zero
        cyc(1, 0, 16'h7FEF, 8'h00, "R5");
        // back to boot mode
        cyc(1, 1, 16'h7FF1, 8'h07, "R6");
        cyc(1, 0, 16'hA000, 8'h00, "R3");
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            logic        v, w;
            a = 16'($urandom);
            d = 8'($urandom);
            v = ($urandom % 8) != 0;
            w = ($urandom % 2) == 1;
            if (($urandom % 4) == 0) a = {12'h7FF, 4'($urandom % 3)};
            cyc(v, w, a, d, "");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule